// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a cycle-accurate model of a byte-wide serial EEPROM that answers as a slave on a two-wire bus with one clock line and one data line. A fast system clock oversamples both lines. The block detects bus start and stop conditions and checks a device select byte against three strap inputs. It then takes a two-byte memory address and either accepts data or returns data. The array holds 4096 bytes. It is grouped into 128 pages of 32 bytes, and the array is a register array inside the block.

Write data collects in a one-page buffer. Only the stop condition that closes a write moves the buffered bytes into the array, all in the same cycle. A programming interval then follows, counted in system clocks, and during that interval the block does not answer its select byte. A write-protect input held high at that stop discards the buffered bytes. Reads may start at an address loaded by a preceding address-only write, and the master can keep reading bytes in sequence until it declines to acknowledge one.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_low_o` = 0) and every array byte reads back as 8'hFF.
- R2: The select byte is, MSB first, the type code 4'b1010, then three bits compared with `cs_i[2:0]` (`cs_i[2]` first), then the direction bit (1 = read). The block acknowledges a matching byte. A byte that does not match gets no acknowledge, and the block then ignores the bus until the next start condition.
- R3: A write consists of the select byte with direction 0, an address high byte (only its low 4 bits are used), an address low byte, and then data bytes. The block acknowledges every one of these bytes by pulling the data line low for the whole ninth clock pulse.
- R4: One write may carry any number of data bytes. The address counter wraps inside the current 32-byte page, and a later byte overwrites an earlier byte at the same offset. At the closing stop, all buffered bytes of the page go into the array together, and bytes of the page that were not written keep their old value.
- R5: A start condition that arrives before the stop of a write discards the buffered data, and the array stays unchanged.
- R6: The stop that commits a write starts a programming interval of `PROG_CYCLES` system clocks. During that interval the select byte is not acknowledged. After it, the select byte is acknowledged again.
- R7: If `wp_i` is high at the closing stop, the array does not change and no programming interval starts.
- R8: A random read loads the address with a write that has no data, then issues a repeated start and a read select. The byte at that address is returned MSB first.
- R9: In a read, the address advances after each byte and wraps from 4095 to 0. When the master does not acknowledge a byte, the read ends and the data line stays released.
- R10: The block changes the data line only while the clock line is low, after a falling clock edge. It samples input bits on rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as resolved on the wire |
| cs_i | input | 3 | Strap inputs compared with the select byte |
| wp_i | input | 1 | Write protect, active high |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain enable) |

## Verification
The assertions assume that every bus clock phase lasts several system clocks. They also assume that the master changes the data line only while the clock line is low, except when it makes a start or stop, and that it never issues a stop while the block is pulling the data line low. The bench drives the bus with each quarter bit period set to four system clocks and only moves the data line in the low phase. The wired-AND line is formed from the master's drive and `sda_low_o`. A stop is issued only after a write acknowledge, or after a read byte that the master did not acknowledge, so the block has always released the line by then.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } bus_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_edge_det.sv
module i2c_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  // [1] is the synced level, [2] the previous one
  assign scl_o   = scl_q[1];
  assign sda_o   = sda_q[1];
  assign rise_o  = scl_q[1] & ~scl_q[2];
  assign fall_o  = ~scl_q[1] & scl_q[2];
  assign start_o = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [PW-1:0]           idx_i,
  input  logic [7:0]              byte_i,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g*8 +: 8] <= 8'h00;
        mask_o[g]        <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (wr_i && idx_i == PW'(g)) begin
        data_o[g*8 +: 8] <= byte_i;
        mask_o[g]        <= 1'b1;
      end
    end
  end

  p_slot_marked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> mask_o[$past(idx_i)]);
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 32,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int PW  = $clog2(PAGE_BYTES),
  localparam int PGW = AW - PW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [PGW-1:0]          page_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [7:0]              rd_data_o
);
  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int k = 0; k < PAGE_BYTES; k++)
        if (mask_i[k]) mem_q[{page_i, PW'(k)}] <= data_i[k*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  p_mem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) && $stable(rd_addr_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] cs_i,
  input  logic       wp_i,
  output logic       sda_low_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic scl_s, sda_s, rise, fall, start, stop;
  bus_st_e st_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q, hi_q, tx_q;
  logic [AW-1:0] addr_q;
  logic rd_mode_q, mack_q, sda_low_q, wr_pend_q;
  logic busy_q;
  logic [TW-1:0] tmr_q;
  logic buf_wr, commit;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0] buf_mask;
  logic [7:0] rd_data;

  i2c_edge_det u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  assign buf_wr = (st_q == ST_WDAT) && fall && (cnt_q == 4'd8);
  assign commit = stop && wr_pend_q && !wp_i && !busy_q;

  eeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clr_i (start),
    .wr_i  (buf_wr),
    .idx_i (addr_q[PW-1:0]),
    .byte_i(shreg_q),
    .data_o(buf_data),
    .mask_o(buf_mask)
  );

  eeprom_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .page_i   (addr_q[AW-1:PW]),
    .data_i   (buf_data),
    .mask_i   (buf_mask),
    .rd_addr_i(addr_q),
    .rd_data_o(rd_data)
  );

  // programming interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (commit) begin
      busy_q <= 1'b1;
      tmr_q  <= TW'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      hi_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
      sda_low_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (start) begin
      st_q      <= ST_DEV;
      cnt_q     <= '0;
      sda_low_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (stop) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sda_low_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (rise) begin
        if (cnt_q < 4'd9) cnt_q <= cnt_q + 4'd1;
        if (cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_s};
        if (cnt_q == 4'd8) mack_q <= !sda_s;
      end else if (fall) begin
        if (cnt_q == 4'd8) begin
          unique case (st_q)
            ST_DEV: begin
              if (shreg_q[7:4] == DEV_TYPE && shreg_q[3:1] == cs_i && !busy_q) begin
                sda_low_q <= 1'b1;
                rd_mode_q <= shreg_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              hi_q      <= shreg_q;
              sda_low_q <= 1'b1;
            end
            ST_ALO: begin
              addr_q    <= AW'({hi_q, shreg_q});
              sda_low_q <= 1'b1;
            end
            ST_WDAT: begin
              addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
              wr_pend_q      <= 1'b1;
              sda_low_q      <= 1'b1;
            end
            ST_RDAT: sda_low_q <= 1'b0;
            default: ;
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_q     <= '0;
          sda_low_q <= 1'b0;
          unique case (st_q)
            ST_DEV: begin
              if (rd_mode_q) begin
                st_q      <= ST_RDAT;
                tx_q      <= rd_data;
                sda_low_q <= !rd_data[7];
                addr_q    <= addr_q + 1'b1;
              end else begin
                st_q <= ST_AHI;
              end
            end
            ST_AHI: st_q <= ST_ALO;
            ST_ALO: st_q <= ST_WDAT;
            ST_RDAT: begin
              if (mack_q) begin
                tx_q      <= rd_data;
                sda_low_q <= !rd_data[7];
                addr_q    <= addr_q + 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (st_q == ST_RDAT && cnt_q != 4'd0) begin
          sda_low_q <= !tx_q[3'(4'd7 - cnt_q)];
        end
      end
    end
  end

  assign sda_low_o = sda_low_q;

  p_idle_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE |-> !sda_low_q);

  p_bit_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd9);

  p_busy_nack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && fall && cnt_q == 4'd8 && st_q == ST_DEV |=> !sda_low_q);

  p_commit_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy_q);

  p_busy_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && tmr_q != '0 |=> busy_q && tmr_q == $past(tmr_q) - 1'b1);

  p_drive_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_q) |-> !scl_s);
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int PROG       = 400;
  localparam int MEMN       = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] cs = 3'b000;
  logic wp = 1'b0;
  logic sda_low;
  wire  sda_line = sda_m & ~sda_low;

  int checks = 0;
  int errors = 0;
  int drive_viol = 0;
  logic [7:0] exp_mem [MEMN];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_slave #(.PROG_CYCLES(PROG)) u_eeprom_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .cs_i(cs), .wp_i(wp), .sda_low_o(sda_low)
  );

  // R10: slave may only assert its pull-down while the bus clock is low
  logic sda_low_d = 1'b0;
  always @(posedge clk) begin
    if (sda_low && !sda_low_d && scl_m) drive_viol++;
    sda_low_d <= sda_low;
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = !sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      d[i] = sda_line; wq();
      scl_m = 1'b0;
    end
    wq();
    sda_m = !mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 37);
  endfunction

  task automatic write_bytes(int a, int n, int seed, bit wait_done);
    bit ack;
    bus_start();
    send_byte({4'b1010, cs, 1'b0}, ack); check_eq("R3 select ack", ack, 1);
    send_byte(8'(a >> 8), ack);          check_eq("R3 addr hi ack", ack, 1);
    send_byte(8'(a), ack);               check_eq("R3 addr lo ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i), ack);
      check_eq("R3 data ack", ack, 1);
      if (!wp) exp_mem[(a & ~31) | ((a + i) & 31)] = pat(seed, i);
    end
    bus_stop();
    if (wait_done) repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic read_bytes(string req, int a, int n);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, cs, 1'b0}, ack);
    send_byte(8'(a >> 8), ack);
    send_byte(8'(a), ack);
    bus_start();
    send_byte({4'b1010, cs, 1'b1}, ack); check_eq({req, " read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check_eq(req, d, exp_mem[(a + i) % MEMN]);
    end
    check_eq("R9 released after master nack", sda_low, 0);
    bus_stop();
  endtask

  task automatic select_probe(string req, int exp_ack);
    bit ack;
    bus_start();
    send_byte({4'b1010, cs, 1'b0}, ack);
    check_eq(req, ack, exp_ack);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < MEMN; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check_eq("R1 sda released after reset", sda_low, 0);

    // R2: every strap value against every select value
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 8; s++) begin
        cs = 3'(c);
        bus_start();
        send_byte({4'b1010, 3'(s), 1'b0}, ack);
        check_eq("R2 select match", ack, int'(s == c));
        if (s != c) begin
          send_byte(8'h00, ack);
          check_eq("R2 ignored after mismatch", ack, 0);
        end
        bus_stop();
      end
    end
    cs = 3'b101;
    bus_start();
    send_byte({4'b1011, cs, 1'b0}, ack);
    check_eq("R2 wrong type code", ack, 0);
    bus_stop();

    read_bytes("R1 erased contents", 12'h123, 2);

    // R3 single byte, R6 busy then ready
    write_bytes(12'h045, 1, 8'h5A, 1'b0);
    select_probe("R6 nack while programming", 0);
    repeat (PROG + 50) @(negedge clk);
    select_probe("R6 ack after programming", 1);
    read_bytes("R3 single byte readback", 12'h044, 3);

    // R4 page write with wrap and overwrite
    write_bytes(12'h0BE, 40, 8'h13, 1'b1);
    read_bytes("R4 page contents", 12'h0A0, 32);
    read_bytes("R4 next page untouched", 12'h0C0, 1);
    write_bytes(12'h0A4, 2, 8'hC1, 1'b1);
    read_bytes("R4 partial page merge", 12'h0A0, 8);

    // R5 repeated start discards buffered bytes
    bus_start();
    send_byte({4'b1010, cs, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_byte(8'h00, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte({4'b1010, cs, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte({4'b1010, cs, 1'b1}, ack);
    recv_byte(1'b0, d);
    check_eq("R5 discarded write", d, 8'hFF);
    bus_stop();
    select_probe("R5 no programming interval", 1);

    // R7 write protect
    wp = 1'b1;
    write_bytes(12'h300, 4, 8'h77, 1'b0);
    select_probe("R7 no programming interval", 1);
    wp = 1'b0;
    read_bytes("R7 array unchanged", 12'h300, 4);

    // R8 MSB-first random read of asymmetric values
    write_bytes(12'h501, 2, 8'h01, 1'b1);
    read_bytes("R8 random read", 12'h501, 1);
    read_bytes("R8 random read second", 12'h502, 1);

    // R9 sequential read wrap 4095 -> 0
    write_bytes(12'hFFE, 2, 8'h3C, 1'b1);
    write_bytes(12'h000, 1, 8'h77, 1'b1);
    read_bytes("R9 sequential wrap", 12'hFFE, 4);

    check_eq("R10 drive only while scl low", drive_viol, 0);

    report();
    $finish;
  end
endmodule